// File: doc/BRIEF.md
# Parallel NOR Flash Geometry Probe

This block runs the discovery sequence for a 16-bit parallel NOR flash, then stops. A single start pulse makes it put the part into CFI query mode and confirm the identification string. It then reads the command-set code, the device size, the write-buffer size and up to two erase-region descriptors. It decodes these into registered geometry outputs: block counts, block sizes, byte start and end addresses of each region, and the largest block size.

Some parts do not answer the first query. The block then tries two recoveries, always in the same order. First it forces asynchronous reads and queries again. If the part still does not answer and a pair of reads toggles, it applies a write-buffer-abort reset and queries once more.

Every run ends the same way, whether it succeeds or fails. The block writes the read-array command to address 0 and drops chip enable. At that moment it raises either `done` or `error`. Flash access goes through an abstract word port: the block holds a request until the responder acknowledges it, and read data arrives with the acknowledge.

Top module: `nor_geom_probe`

## Requirements
- R1: `start` is accepted only while the block is idle (never started, or after `done`/`error`). A `start` during a run, including the cycle in which the final access is acknowledged, has no effect.
- R2: The first access of a run writes 0x0098 to word address 0x55. The identification check then reads 0x10, 0x11 and 0x12 and compares their low bytes with 0x51, 0x52 and 0x59 ('Q','R','Y').
- R3: If the first read of 0x10 does not give 'Q', the block writes 0x0060 and then 0x0003 to address 0xF94F, rewrites the query, and reads 0x10 again.
- R4: If that second read also fails, the block reads 0x10 twice more. If the two words differ in any bit of mask 0x0044, it writes 0xAA to 0x555, then 0x55 to 0x2AA, then 0xF0 to 0x555, and rewrites the query. Without such a difference, no reset is written.
- R5: An identification mismatch in the final 0x10..0x12 check ends the run with `error` and all geometry outputs zero.
- R6: The command-set code is {low byte of 0x14, low byte of 0x13}. Only 0x0001, 0x0002 and 0x0200 are accepted. Any other code ends the run with `error` before address 0x27 is read.
- R7: The size exponent is the low byte of 0x27. The write-buffer exponent is {low byte of 0x2B, low byte of 0x2A}. The high byte of every table word is ignored.
- R8: The region count is the low byte of 0x2C. A count of zero gives `error` before 0x2D is read. With a count of one, addresses 0x31..0x34 are not read, region 2 reports zero blocks and zero size, and its start and end both equal region 1's end.
- R9: Each region's four bytes form a 32-bit value, lowest address first. Block count is the low 16 bits plus one. Block size is the high 16 bits times 256.
- R10: Region 1 spans from 0 to count×size. Region 2 starts at region 1's end and ends count×size later. `max_bsize` is the larger of the two block sizes.
- R11: Every run ends with a write of 0x00FF to address 0. The cycle that acknowledges this write drops `flash_ce` and raises `done` or `error`.
- R12: The block requests an access only while `flash_ce` is high. The address, direction and write data stay constant until the acknowledge.
- R13: `done` and `error` are never high together. Each holds until the next accepted `start`, which clears it and all geometry outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe run (idle only) |
| acc_req | output | 1 | Word access request, held until acknowledged |
| acc_we | output | 1 | 1 = write, 0 = read |
| acc_addr | output | ADDR_W | Word address |
| acc_wdata | output | 16 | Write data |
| acc_ack | input | 1 | Access complete; read data valid |
| acc_rdata | input | 16 | Read data |
| flash_ce | output | 1 | Chip enable, active high |
| done | output | 1 | Run finished with valid geometry |
| error | output | 1 | Run finished without valid geometry |
| cmd_set | output | 16 | Command-set code |
| size_log2 | output | 8 | Device size exponent (bytes) |
| wbuf_log2 | output | 16 | Write-buffer size exponent (bytes) |
| region_cnt | output | 8 | Erase-region count |
| r1_blocks | output | 17 | Region 1 block count |
| r1_bsize | output | 24 | Region 1 block size in bytes |
| r1_end | output | 42 | Region 1 end byte address |
| r2_blocks | output | 17 | Region 2 block count |
| r2_bsize | output | 24 | Region 2 block size in bytes |
| r2_start | output | 42 | Region 2 start byte address |
| r2_end | output | 42 | Region 2 end byte address |
| max_bsize | output | 24 | Largest erase block size |

## Verification
Two events can land in the same cycle: the acknowledge of the closing read-array write, and a new `start` pulse. The bench waits until the responder has raised the acknowledge for the 0x00FF write to address 0, and holds `start` high across that same clock edge. The run passes if `done` rises, `flash_ce` falls, and no further request appears afterwards. A new query write showing up in the access log would mean the pulse was wrongly taken as a restart.

// File: rtl/nor_geom_probe.sv
module nor_geom_probe #(
  parameter int ADDR_W = 24,
  localparam int END_W = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              acc_req,
  output logic              acc_we,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [15:0]       acc_wdata,
  input  logic              acc_ack,
  input  logic [15:0]       acc_rdata,
  output logic              flash_ce,
  output logic              done,
  output logic              error,
  output logic [15:0]       cmd_set,
  output logic [7:0]        size_log2,
  output logic [15:0]       wbuf_log2,
  output logic [7:0]        region_cnt,
  output logic [16:0]       r1_blocks,
  output logic [23:0]       r1_bsize,
  output logic [END_W-1:0]  r1_end,
  output logic [16:0]       r2_blocks,
  output logic [23:0]       r2_bsize,
  output logic [END_W-1:0]  r2_start,
  output logic [END_W-1:0]  r2_end,
  output logic [23:0]       max_bsize
);
  localparam int TBL_N = 14;

  typedef enum logic [4:0] {
    IDLE, QRY_W, ID0_R, ASY_W1, ASY_W2, QRY2_W, ID0B_R, TOG_R1, TOG_R2,
    AB_W1, AB_W2, AB_W3, QRY3_W, IDC_R, TBL_R, CALC, EXIT_W
  } st_t;

  st_t         st;
  logic [3:0]  ix;
  logic        fail;
  logic [15:0] tog_a;
  logic [7:0]  tb [TBL_N];

  function automatic logic [7:0] id_byte(input logic [3:0] i);
    case (i)
      4'd0:    return 8'h51;
      4'd1:    return 8'h52;
      default: return 8'h59;
    endcase
  endfunction

  function automatic logic [15:0] tbl_addr(input logic [3:0] i);
    if (i < 4'd2)       return 16'h0013 + 16'(i);
    else if (i == 4'd2) return 16'h0027;
    else                return 16'h0027 + 16'(i);
  endfunction

  assign acc_req = (st != IDLE) && (st != CALC);

  always_comb begin
    acc_we    = 1'b0;
    acc_addr  = '0;
    acc_wdata = 16'h0000;
    case (st)
      QRY_W, QRY2_W, QRY3_W: begin acc_we = 1'b1; acc_addr = ADDR_W'(16'h0055); acc_wdata = 16'h0098; end
      ASY_W1: begin acc_we = 1'b1; acc_addr = ADDR_W'(16'hF94F); acc_wdata = 16'h0060; end
      ASY_W2: begin acc_we = 1'b1; acc_addr = ADDR_W'(16'hF94F); acc_wdata = 16'h0003; end
      AB_W1:  begin acc_we = 1'b1; acc_addr = ADDR_W'(16'h0555); acc_wdata = 16'h00AA; end
      AB_W2:  begin acc_we = 1'b1; acc_addr = ADDR_W'(16'h02AA); acc_wdata = 16'h0055; end
      AB_W3:  begin acc_we = 1'b1; acc_addr = ADDR_W'(16'h0555); acc_wdata = 16'h00F0; end
      EXIT_W: begin acc_we = 1'b1; acc_addr = '0; acc_wdata = 16'h00FF; end
      ID0_R, ID0B_R, TOG_R1, TOG_R2: acc_addr = ADDR_W'(16'h0010);
      IDC_R:  acc_addr = ADDR_W'(16'h0010 + 16'(ix));
      TBL_R:  acc_addr = ADDR_W'(tbl_addr(ix));
      default: ;
    endcase
  end

  logic             two_reg;
  logic [16:0]      c_r1b, c_r2b;
  logic [23:0]      c_r1s, c_r2s;
  logic [END_W-1:0] c_r1e, c_r2e;

  assign two_reg = tb[5] > 8'd1;
  assign c_r1b   = {1'b0, tb[7], tb[6]} + 17'd1;
  assign c_r1s   = {tb[9], tb[8], 8'h00};
  assign c_r2b   = two_reg ? {1'b0, tb[11], tb[10]} + 17'd1 : 17'd0;
  assign c_r2s   = two_reg ? {tb[13], tb[12], 8'h00} : 24'd0;
  assign c_r1e   = END_W'(c_r1b) * END_W'(c_r1s);
  assign c_r2e   = c_r1e + END_W'(c_r2b) * END_W'(c_r2s);

  always_ff @(posedge clk)
    if (st == TBL_R && acc_ack) tb[ix] <= acc_rdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ix <= '0; fail <= 1'b0; tog_a <= '0;
      flash_ce <= 1'b0; done <= 1'b0; error <= 1'b0;
      cmd_set <= '0; size_log2 <= '0; wbuf_log2 <= '0; region_cnt <= '0;
      r1_blocks <= '0; r1_bsize <= '0; r1_end <= '0;
      r2_blocks <= '0; r2_bsize <= '0; r2_start <= '0; r2_end <= '0; max_bsize <= '0;
    end else if (st == IDLE) begin
      if (start) begin
        st <= QRY_W; ix <= '0; fail <= 1'b0;
        flash_ce <= 1'b1; done <= 1'b0; error <= 1'b0;
        cmd_set <= '0; size_log2 <= '0; wbuf_log2 <= '0; region_cnt <= '0;
        r1_blocks <= '0; r1_bsize <= '0; r1_end <= '0;
        r2_blocks <= '0; r2_bsize <= '0; r2_start <= '0; r2_end <= '0; max_bsize <= '0;
      end
    end else if (st == CALC) begin
      cmd_set    <= {tb[1], tb[0]};
      size_log2  <= tb[2];
      wbuf_log2  <= {tb[4], tb[3]};
      region_cnt <= tb[5];
      r1_blocks  <= c_r1b;
      r1_bsize   <= c_r1s;
      r1_end     <= c_r1e;
      r2_blocks  <= c_r2b;
      r2_bsize   <= c_r2s;
      r2_start   <= c_r1e;
      r2_end     <= c_r2e;
      max_bsize  <= (c_r2s > c_r1s) ? c_r2s : c_r1s;
      st         <= EXIT_W;
    end else if (acc_ack) begin
      case (st)
        QRY_W:  st <= ID0_R;
        ID0_R:  begin ix <= '0; st <= (acc_rdata[7:0] == 8'h51) ? IDC_R : ASY_W1; end
        ASY_W1: st <= ASY_W2;
        ASY_W2: st <= QRY2_W;
        QRY2_W: st <= ID0B_R;
        ID0B_R: begin ix <= '0; st <= (acc_rdata[7:0] == 8'h51) ? IDC_R : TOG_R1; end
        TOG_R1: begin tog_a <= acc_rdata; st <= TOG_R2; end
        TOG_R2: begin ix <= '0; st <= (((tog_a ^ acc_rdata) & 16'h0044) != 16'h0) ? AB_W1 : IDC_R; end
        AB_W1:  st <= AB_W2;
        AB_W2:  st <= AB_W3;
        AB_W3:  st <= QRY3_W;
        QRY3_W: begin ix <= '0; st <= IDC_R; end
        IDC_R: begin
          if (acc_rdata[7:0] != id_byte(ix)) begin fail <= 1'b1; st <= EXIT_W; end
          else if (ix == 4'd2) begin ix <= '0; st <= TBL_R; end
          else ix <= ix + 4'd1;
        end
        TBL_R: begin
          if (ix == 4'd1 && !({acc_rdata[7:0], tb[0]} inside {16'h0001, 16'h0002, 16'h0200})) begin
            fail <= 1'b1; st <= EXIT_W;
          end else if (ix == 4'd5 && acc_rdata[7:0] == 8'h00) begin
            fail <= 1'b1; st <= EXIT_W;
          end else if ((ix == 4'd9 && tb[5] == 8'd1) || ix == 4'(TBL_N - 1)) begin
            st <= CALC;
          end else ix <= ix + 4'd1;
        end
        EXIT_W: begin
          st <= IDLE; flash_ce <= 1'b0; done <= !fail; error <= fail;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_ce_covers_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> flash_ce);
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_addr) && $stable(acc_we) && $stable(acc_wdata));
  assert_exit_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) || $rose(error)) |-> !flash_ce &&
      $past(acc_req && acc_ack && acc_we && acc_addr == '0 && acc_wdata == 16'h00FF));
  assert_flags_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_flag_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) && !start |=> $stable(done) && $stable(error));
  assert_cmd_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_set inside {16'h0001, 16'h0002, 16'h0200});
  assert_region_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> r2_start == r1_end && r2_end >= r2_start && max_bsize >= r1_bsize);
  assert_count_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> region_cnt != 8'd0 && r1_blocks != 17'd0);
endmodule

// File: tb/nor_geom_probe_tb.sv
module nor_geom_probe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic acc_req, acc_we, acc_ack = 1'b0, flash_ce, done, error;
  logic [ADDR_W-1:0] acc_addr;
  logic [15:0] acc_wdata, acc_rdata = 16'h0;
  logic [15:0] cmd_set, wbuf_log2;
  logic [7:0]  size_log2, region_cnt;
  logic [16:0] r1_blocks, r2_blocks;
  logic [23:0] r1_bsize, r2_bsize, max_bsize;
  logic [41:0] r1_end, r2_start, r2_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_geom_probe #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ack(acc_ack), .acc_rdata(acc_rdata), .flash_ce(flash_ce),
    .done(done), .error(error), .cmd_set(cmd_set), .size_log2(size_log2),
    .wbuf_log2(wbuf_log2), .region_cnt(region_cnt),
    .r1_blocks(r1_blocks), .r1_bsize(r1_bsize), .r1_end(r1_end),
    .r2_blocks(r2_blocks), .r2_bsize(r2_bsize), .r2_start(r2_start), .r2_end(r2_end),
    .max_bsize(max_bsize));

  int total = 0, fails = 0;
  bit finished = 0;

  // behavioural flash
  logic [7:0] cb [64];
  int  lat = 0;
  bit  query = 0, sync_st = 0, abort_st = 0;
  int  ab_ph = 0;
  bit  as_ph = 0;
  logic [15:0] tog_v = 16'h0080;
  bit  lg_we [512];
  logic [15:0] lg_addr [512];
  logic [15:0] lg_data [512];
  int  lg_n = 0;

  initial begin
    int wc;
    wc = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin acc_ack = 1'b0; wc = 0; end
      else if (acc_ack) acc_ack = 1'b0;
      else if (acc_req) begin
        if (wc >= lat) begin
          wc = 0;
          acc_ack = 1'b1;
          if (lg_n < 512) begin
            lg_we[lg_n] = acc_we; lg_addr[lg_n] = acc_addr[15:0]; lg_data[lg_n] = acc_wdata;
          end
          lg_n++;
          if (acc_we) begin
            if (acc_addr == 24'h55 && acc_wdata == 16'h98 && !abort_st) query = 1;
            if (acc_wdata == 16'hFF) query = 0;
            if (acc_addr == 24'hF94F && acc_wdata == 16'h60) as_ph = 1;
            else if (acc_addr == 24'hF94F && acc_wdata == 16'h03 && as_ph) begin sync_st = 0; as_ph = 0; end
            else as_ph = 0;
            if (acc_addr == 24'h555 && acc_wdata == 16'hAA) ab_ph = 1;
            else if (acc_addr == 24'h2AA && acc_wdata == 16'h55 && ab_ph == 1) ab_ph = 2;
            else if (acc_addr == 24'h555 && acc_wdata == 16'hF0 && ab_ph == 2) begin
              ab_ph = 0; abort_st = 0; query = 0;
            end else ab_ph = 0;
          end else begin
            if (abort_st) begin tog_v = tog_v ^ 16'h0040; acc_rdata = tog_v; end
            else if (sync_st) acc_rdata = 16'h1234;
            else if (query && acc_addr < 24'h40) acc_rdata = {8'hA5, cb[acc_addr[5:0]]};
            else acc_rdata = acc_addr[15:0] ^ 16'h5A5A;
          end
        end else wc++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int find_w(input int from, input logic [15:0] a, input logic [15:0] d);
    for (int i = from; i < lg_n && i < 512; i++)
      if (lg_we[i] && lg_addr[i] == a && lg_data[i] == d) return i;
    return -1;
  endfunction

  function automatic int cnt_rd(input logic [15:0] a);
    int n = 0;
    for (int i = 0; i < lg_n && i < 512; i++) if (!lg_we[i] && lg_addr[i] == a) n++;
    return n;
  endfunction

  function automatic int cnt_w(input logic [15:0] a, input logic [15:0] d);
    int n = 0;
    for (int i = 0; i < lg_n && i < 512; i++) if (lg_we[i] && lg_addr[i] == a && lg_data[i] == d) n++;
    return n;
  endfunction

  logic [15:0] e_r1c, e_r1s, e_r2c, e_r2s;
  logic [7:0]  e_cnt;

  task automatic set_cfg(input logic [23:0] id, input logic [15:0] cs, input logic [7:0] dsz,
                         input logic [15:0] wb, input logic [7:0] cnt,
                         input logic [15:0] a1, input logic [15:0] s1,
                         input logic [15:0] a2, input logic [15:0] s2);
    for (int i = 0; i < 64; i++) cb[i] = 8'h00;
    cb[6'h10] = id[23:16]; cb[6'h11] = id[15:8]; cb[6'h12] = id[7:0];
    cb[6'h13] = cs[7:0]; cb[6'h14] = cs[15:8]; cb[6'h27] = dsz;
    cb[6'h2A] = wb[7:0]; cb[6'h2B] = wb[15:8]; cb[6'h2C] = cnt;
    cb[6'h2D] = a1[7:0]; cb[6'h2E] = a1[15:8]; cb[6'h2F] = s1[7:0]; cb[6'h30] = s1[15:8];
    cb[6'h31] = a2[7:0]; cb[6'h32] = a2[15:8]; cb[6'h33] = s2[7:0]; cb[6'h34] = s2[15:8];
    e_r1c = a1; e_r1s = s1; e_r2c = a2; e_r2s = s2; e_cnt = cnt;
  endtask

  bit ce_before;

  task automatic probe();
    int n;
    lg_n = 0; query = 0;
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    n = 0; ce_before = 0;
    while (!(done || error) && n < 20000) begin
      ce_before = flash_ce; @(negedge clk); #2; n++;
    end
  endtask

  task automatic chk_geom(input string tag);
    logic [63:0] b1, z1, e1, b2, z2, e2, mx;
    b1 = 64'(e_r1c) + 1; z1 = 64'(e_r1s) * 256; e1 = b1 * z1;
    if (e_cnt > 1) begin b2 = 64'(e_r2c) + 1; z2 = 64'(e_r2s) * 256; end
    else begin b2 = 0; z2 = 0; end
    e2 = e1 + b2 * z2;
    mx = (z2 > z1) ? z2 : z1;
    chk({tag, " R9 r1_blocks"}, 64'(r1_blocks), b1);
    chk({tag, " R9 r1_bsize"}, 64'(r1_bsize), z1);
    chk({tag, " R10 r1_end"}, 64'(r1_end), e1);
    chk({tag, " R9 r2_blocks"}, 64'(r2_blocks), b2);
    chk({tag, " R9 r2_bsize"}, 64'(r2_bsize), z2);
    chk({tag, " R10 r2_start"}, 64'(r2_start), e1);
    chk({tag, " R10 r2_end"}, 64'(r2_end), e2);
    chk({tag, " R10 max_bsize"}, 64'(max_bsize), mx);
    chk({tag, " R8 region_cnt"}, 64'(region_cnt), 64'(e_cnt));
  endtask

  task automatic chk_exit(input string tag);
    chk({tag, " R11 last access is FF@0"},
        {32'(lg_n), 15'd0, lg_we[lg_n-1], lg_addr[lg_n-1], lg_data[lg_n-1]},
        {32'(lg_n), 15'd0, 1'b1, 16'h0000, 16'h00FF});
    chk({tag, " R11 ce dropped with flag"}, {63'd0, flash_ce}, 64'd0);
    chk({tag, " R11 ce high the cycle before"}, {63'd0, ce_before}, 64'd1);
    chk({tag, " R12 no request after finish"}, {63'd0, acc_req}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R13 reset done", {63'd0, done}, 0);
    chk("R13 reset error", {63'd0, error}, 0);
    chk("R12 reset ce", {63'd0, flash_ce}, 0);
    chk("R12 reset req", {63'd0, acc_req}, 0);
  endtask

  task automatic t_normal();
    lat = 0; sync_st = 0; abort_st = 0;
    set_cfg(24'h515259, 16'h0001, 8'h18, 16'h0006, 8'd2, 16'h0003, 16'h0080, 16'h00FE, 16'h0200);
    probe();
    chk("R2 normal done", {62'd0, done, error}, 64'd2);
    chk("R2 first access is query write", {15'd0, lg_we[0], lg_addr[0], lg_data[0]}, {15'd0, 1'b1, 16'h55, 16'h98});
    chk("R2 id reads", {32'(cnt_rd(16'h11)), 32'(cnt_rd(16'h12))}, {32'd1, 32'd1});
    chk("R3 no async writes when Q present", 64'(cnt_w(16'hF94F, 16'h60)), 0);
    chk("R6 cmd_set", 64'(cmd_set), 64'h0001);
    chk("R7 size_log2", 64'(size_log2), 64'h18);
    chk("R7 wbuf_log2", 64'(wbuf_log2), 64'h6);
    chk_geom("normal");
    chk_exit("normal");
    repeat (20) @(negedge clk);
    chk("R13 done held", {62'd0, done, error}, 64'd2);
  endtask

  task automatic t_sync();
    int i0, i1, q2;
    lat = 3; sync_st = 1; abort_st = 0;
    set_cfg(24'h515259, 16'h0200, 8'h1A, 16'h0100, 8'd1, 16'h00FF, 16'h0100, 16'h1234, 16'h5678);
    probe();
    i0 = find_w(0, 16'hF94F, 16'h60); i1 = find_w(0, 16'hF94F, 16'h03); q2 = find_w(1, 16'h55, 16'h98);
    chk("R3 async order", {i0 > 0 && i1 == i0 + 1 && q2 == i1 + 1, 63'd0}, {1'b1, 63'd0});
    chk("R4 no abort reset needed", 64'(cnt_w(16'h555, 16'hAA)), 0);
    chk("R3 sync recovered done", {62'd0, done, error}, 64'd2);
    chk("R6 cmd 0200", 64'(cmd_set), 64'h0200);
    chk("R7 wbuf high byte", 64'(wbuf_log2), 64'h0100);
    chk("R8 region2 not read", 64'(cnt_rd(16'h31) + cnt_rd(16'h34)), 0);
    chk_geom("sync");
    chk_exit("sync");
  endtask

  task automatic t_abort();
    int a, b, c, q;
    lat = 1; sync_st = 0; abort_st = 1;
    set_cfg(24'h515259, 16'h0002, 8'h1B, 16'h0009, 8'd2, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001);
    probe();
    a = find_w(0, 16'h555, 16'hAA); b = find_w(0, 16'h2AA, 16'h55);
    c = find_w(0, 16'h555, 16'hF0); q = find_w(c < 0 ? 0 : c, 16'h55, 16'h98);
    chk("R4 abort sequence order", {a > 0 && b == a + 1 && c == b + 1 && q == c + 1, 63'd0}, {1'b1, 63'd0});
    chk("R3 async tried before abort", {find_w(0, 16'hF94F, 16'h03) < a, 63'd0}, {1'b1, 63'd0});
    chk("R4 abort recovered done", {62'd0, done, error}, 64'd2);
    chk("R6 cmd 0002", 64'(cmd_set), 64'h0002);
    chk_geom("abort");
    chk_exit("abort");
  endtask

  task automatic t_bad_id();
    lat = 0; sync_st = 0; abort_st = 0;
    set_cfg(24'h515258, 16'h0001, 8'h18, 16'h0006, 8'd1, 16'h0003, 16'h0080, 16'h0, 16'h0);
    probe();
    chk("R5 bad id error", {62'd0, done, error}, 64'd1);
    chk("R5 outputs zero", {r1_end[31:0], 16'(cmd_set), 16'(max_bsize[15:0])}, 0);
    chk("R5 no table reads", 64'(cnt_rd(16'h13)), 0);
    chk_exit("badid");
    sync_st = 1;
    set_cfg(24'h515259, 16'h0001, 8'h18, 16'h0006, 8'd1, 16'h0003, 16'h0080, 16'h0, 16'h0);
    for (int i = 0; i < 64; i++) cb[i] = 8'h00;
    probe();
    chk("R4 stable reads skip reset", 64'(cnt_w(16'h555, 16'hAA)), 0);
    chk("R4 toggle pair read", 64'(cnt_rd(16'h10) >= 4), 1);
    chk("R5 unreadable error", {62'd0, done, error}, 64'd1);
  endtask

  task automatic t_bad_cmd();
    lat = 2; sync_st = 0; abort_st = 0;
    set_cfg(24'h515259, 16'h0003, 8'h18, 16'h0006, 8'd1, 16'h0003, 16'h0080, 16'h0, 16'h0);
    probe();
    chk("R6 unknown cmd error", {62'd0, done, error}, 64'd1);
    chk("R6 stops before 0x27", 64'(cnt_rd(16'h27)), 0);
    chk_exit("badcmd");
    set_cfg(24'h515259, 16'h0002, 8'h18, 16'h0006, 8'd0, 16'h0003, 16'h0080, 16'h0, 16'h0);
    probe();
    chk("R8 zero count error", {62'd0, done, error}, 64'd1);
    chk("R8 stops before 0x2D", 64'(cnt_rd(16'h2D)), 0);
    chk("R8 outputs zero", 64'(region_cnt), 0);
    chk_exit("zerocnt");
  endtask

  task automatic t_start_overlap();
    int n;
    lat = 0; sync_st = 0; abort_st = 0;
    set_cfg(24'h515259, 16'h0001, 8'h17, 16'h0005, 8'd2, 16'h0001, 16'h0040, 16'h0002, 16'h0020);
    lg_n = 0; query = 0;
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    chk("R13 start clears done", {62'd0, done, error}, 0);
    chk("R13 start clears outputs", 64'(r1_end), 0);
    repeat (4) @(negedge clk);
    #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    n = 0;
    forever begin
      @(negedge clk); #2; n++;
      if ((acc_ack && acc_we && acc_addr == '0 && acc_wdata == 16'h00FF) || n > 5000) break;
    end
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk); #2;
    chk("R1 overlap finishes done", {62'd0, done, error}, 64'd2);
    chk("R11 overlap ce low", {63'd0, flash_ce}, 0);
    n = lg_n;
    repeat (10) @(negedge clk);
    chk("R1 start at final ack ignored", 64'(lg_n - n), 0);
    chk("R1 mid-run start ignored", 64'(cnt_w(16'h55, 16'h98)), 1);
    chk("R1 still done", {62'd0, done, error}, 64'd2);
    chk_geom("overlap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_normal();
    t_sync();
    t_abort();
    t_bad_id();
    t_bad_cmd();
    t_start_overlap();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule